// File: doc/BRIEF.md
# SPI-Attached 16-Bit I/O Expander

This block is an SPI slave that gives a host sixteen general-purpose I/O pins, organised as two 8-bit ports (A and B). The host controls the pins through a small register file. It uses 24-bit frames made of an opcode byte, a register index byte and a data byte. Each pin can be an input or an output. An input can be inverted before the host reads it. An enabled input raises a sticky interrupt when it differs from the value the host last read.

The SPI lines (mode 0, MSB first) are oversampled in the system clock domain through two-stage synchronisers. The serial clock must therefore run well below the system clock. A write takes effect when the 24th bit is received. A read loads the addressed register after the 16th bit, and the slave shifts it out during the third byte. Raising chip select before the frame is complete abandons the frame.

Top module: `io_expander_spi`

## Requirements
- R1: After reset, every pin is an input (`gpio_oe` = 0), `gpio_out` = 0, `irq` = 0, `miso` = 0, the direction registers read 0xFF, and the polarity, interrupt-enable, latch, capture and reference registers are 0.
- R2: A frame is 24 bits, MSB first, with `mosi` sampled on rising `sclk`. Opcode 0x40 writes and opcode 0x41 reads. A frame with any other opcode changes no register and returns 0 on `miso`.
- R3: Register index bit 0 selects the port (0 = A, 1 = B), and bits 3..1 select the register: 0 direction, 1 polarity, 2 interrupt enable, 3 capture, 4 GPIO, 5 output latch. Direction A is therefore index 0x00. Writes to these registers are stored and read back unchanged.
- R4: A write to the GPIO or latch index loads the output latch. A direction bit of 0 makes the pin an output: `gpio_oe` is the inverse of direction, and `gpio_out` carries the latch bit on output pins and 0 on input pins.
- R5: During the third byte of a read frame, `miso` presents the addressed register MSB first, with each bit valid before the rising `sclk` edge on which the host samples it.
- R6: A GPIO read returns, for each input pin, the synchronised input XOR its polarity bit, and for each output pin, the latch bit.
- R7: An input pin whose interrupt-enable bit is set and whose synchronised level differs from its reference bit sets a sticky flag. `irq` is high while any flag is set. Pins that are disabled or configured as outputs never set a flag.
- R8: A read of a port's GPIO or capture index clears that port's flags and loads that port's reference with the present input. The other port's flags are unaffected.
- R9: The capture register of a port holds that port's GPIO read value from the cycle in which its first flag was set.
- R10: Raising `cs_n` before 24 bits have been received discards the frame. Reads of unmapped indices (bits 7..4 non-zero, or bits 3..1 above 5) return 0.
- R11: Writes to the capture index, and to unmapped indices, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| gpio_in | input | 16 | Pin input levels, port B in bits 15..8 |
| gpio_out | output | 16 | Pin output levels |
| gpio_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Interrupt-on-change request |

## Verification
Two functions can land in the same cycle: a read of GPIO or capture that clears a port's flags and reloads its reference, and a new input change that would set a flag. The bench changes an input after the reference has been taken and confirms that `irq` rises again. It also reads one port while the other port's flag is pending and checks that the clear applies only to the port that was addressed. The capture value is judged against the input pattern at the first change, not the later one seen at read time.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
    localparam int PORT_W  = 8;
    localparam int NPORT   = 2;
    localparam int PIN_W   = PORT_W * NPORT;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 3 * BYTE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h41;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_POL  = 3'd1,
        SEL_IEN  = 3'd2,
        SEL_CAP  = 3'd3,
        SEL_GPIO = 3'd4,
        SEL_LAT  = 3'd5
    } reg_sel_e;

    typedef logic [NPORT-1:0][PORT_W-1:0] port_vec_t;
endpackage

// File: rtl/ioexp_spi_rx.sv
module ioexp_spi_rx
    import ioexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_req,
    output logic              wr_req,
    output logic [BYTE_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata,
    output logic              miso
);
    typedef struct packed {
        logic [2:0]         sck;
        logic [1:0]         cs;
        logic [1:0]         mo;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic [BYTE_W-1:0]  adr;
        logic [BYTE_W-1:0]  tx;
        logic               op_wr;
        logic               rd_req;
        logic               wr_req;
    } rx_t;

    rx_t q, d;
    logic rise, fall;

    always_comb begin
        d        = q;
        d.rd_req = 1'b0;
        d.wr_req = 1'b0;
        d.sck    = {q.sck[1:0], sclk};
        d.cs     = {q.cs[0], cs_n};
        d.mo     = {q.mo[0], mosi};
        rise     = q.sck[1] & ~q.sck[2];
        fall     = ~q.sck[1] & q.sck[2];
        if (q.cs[1]) begin
            d.cnt   = '0;
            d.tx    = '0;
            d.op_wr = 1'b0;
        end else begin
            if (q.rd_req) d.tx = rd_data;
            if (rise && q.cnt != CNT_W'(FRAME_W)) begin
                d.sh  = {q.sh[FRAME_W-2:0], q.mo[1]};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(2*BYTE_W-1)) begin
                    d.adr    = d.sh[BYTE_W-1:0];
                    d.op_wr  = (d.sh[2*BYTE_W-1:BYTE_W] == OPC_WRITE);
                    d.rd_req = (d.sh[2*BYTE_W-1:BYTE_W] == OPC_READ);
                end
                if (q.cnt == CNT_W'(FRAME_W-1)) d.wr_req = q.op_wr;
            end else if (fall && q.cnt > CNT_W'(2*BYTE_W)) begin
                d.tx = {q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.sck <= '0;
            q.cs  <= '1;
        end else begin
            q <= d;
        end
    end

    assign rd_req = q.rd_req;
    assign wr_req = q.wr_req;
    assign addr   = q.adr;
    assign wdata  = q.sh[BYTE_W-1:0];
    assign miso   = q.tx[BYTE_W-1];
endmodule

// File: rtl/ioexp_regs.sv
module ioexp_regs
    import ioexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  gpio_in,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_data,
    output logic [PIN_W-1:0]  gpio_out,
    output logic [PIN_W-1:0]  gpio_oe,
    output logic              irq
);
    typedef struct packed {
        port_vec_t in1;
        port_vec_t in2;
        port_vec_t dir;
        port_vec_t pol;
        port_vec_t ien;
        port_vec_t cap;
        port_vec_t lat;
        port_vec_t refv;
        port_vec_t flag;
    } regs_t;

    regs_t     q, d;
    port_vec_t pin_rd, change;
    reg_sel_e  sel;
    logic      port, mapped;

    always_comb begin
        d      = q;
        d.in1  = gpio_in;
        d.in2  = q.in1;
        sel    = reg_sel_e'(addr[3:1]);
        port   = addr[0];
        mapped = (addr[7:4] == 4'h0) && (addr[3:1] <= 3'd5);
        for (int p = 0; p < NPORT; p++) begin
            pin_rd[p] = (q.dir[p] & (q.in2[p] ^ q.pol[p])) | (~q.dir[p] & q.lat[p]);
            change[p] = q.ien[p] & q.dir[p] & (q.in2[p] ^ q.refv[p]);
            d.flag[p] = q.flag[p] | change[p];
            if (q.flag[p] == '0 && change[p] != '0) d.cap[p] = pin_rd[p];
            if (rd_req && mapped && port == 1'(p) && (sel == SEL_GPIO || sel == SEL_CAP)) begin
                d.flag[p] = '0;
                d.refv[p] = q.in2[p];
            end
            if (wr_req && mapped && port == 1'(p)) begin
                case (sel)
                    SEL_DIR:           d.dir[p] = wdata;
                    SEL_POL:           d.pol[p] = wdata;
                    SEL_IEN:           d.ien[p] = wdata;
                    SEL_GPIO, SEL_LAT: d.lat[p] = wdata;
                    default:           ;
                endcase
            end
        end
        rd_data = '0;
        if (mapped) begin
            case (sel)
                SEL_DIR:  rd_data = q.dir[port];
                SEL_POL:  rd_data = q.pol[port];
                SEL_IEN:  rd_data = q.ien[port];
                SEL_CAP:  rd_data = q.cap[port];
                SEL_GPIO: rd_data = pin_rd[port];
                SEL_LAT:  rd_data = q.lat[port];
                default:  rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.dir <= '1;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign gpio_oe[g*PORT_W +: PORT_W]  = ~q.dir[g];
        assign gpio_out[g*PORT_W +: PORT_W] = ~q.dir[g] & q.lat[g];
    end
    assign irq = |q.flag;
endmodule

// File: rtl/io_expander_spi.sv
module io_expander_spi
    import ioexp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             miso,
    input  logic [PIN_W-1:0] gpio_in,
    output logic [PIN_W-1:0] gpio_out,
    output logic [PIN_W-1:0] gpio_oe,
    output logic             irq
);
    logic              rd_req, wr_req;
    logic [BYTE_W-1:0] addr, wdata, rd_data;

    ioexp_spi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .rd_data(rd_data), .rd_req(rd_req), .wr_req(wr_req),
        .addr(addr), .wdata(wdata), .miso(miso)
    );

    ioexp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
        .rd_req(rd_req), .wr_req(wr_req), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
    );
endmodule

// File: rtl/ioexp_sva.sv
module ioexp_sva
    import ioexp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             miso,
    input logic             irq,
    input logic [PIN_W-1:0] gpio_oe,
    input logic [PIN_W-1:0] gpio_out,
    input logic             wr_req,
    input logic             rd_req
);
    // R4: pin direction changes only in the cycle after a completed write frame
    assert_oe_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpio_oe) |-> $past(wr_req));

    // R4: driven levels change only in the cycle after a completed write frame
    assert_out_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpio_out) |-> $past(wr_req));

    // R8: the interrupt drops only because a read request cleared the flags
    assert_irq_clear_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_req));

    // R10: with chip select held high, the serial output stays low
    assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);
endmodule

bind io_expander_spi ioexp_sva u_sva (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .irq(irq),
    .gpio_oe(gpio_oe), .gpio_out(gpio_out), .wr_req(wr_req), .rd_req(rd_req)
);

// File: tb/io_expander_spi_tb.sv
module io_expander_spi_tb;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out, gpio_oe;
    logic        irq;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_dir [2];
    logic [7:0] m_pol [2];
    logic [7:0] m_lat [2];

    always #4 clk = ~clk;

    io_expander_spi u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .gpio_in(gpio_in), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] a, input logic [7:0] dv,
                        input int nbits, output logic [7:0] r);
        logic [23:0] w;
        w = {c, a, dv};
        r = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = w[23-i];
            repeat (HP) @(negedge clk);
            if (i >= 16) r = {r[6:0], miso};
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2*HP) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] dv);
        logic [7:0] r;
        xfer(8'h40, a, dv, 24, r);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] r);
        xfer(8'h41, a, 8'h00, 24, r);
    endtask

    function automatic logic [7:0] exp_gpio(input int p);
        logic [7:0] pin;
        pin = gpio_in[p*8 +: 8];
        return (m_dir[p] & (pin ^ m_pol[p])) | (~m_dir[p] & m_lat[p]);
    endfunction

    function automatic logic [7:0] exp_reg(input logic [2:0] s, input int p);
        case (s)
            3'd0:    return m_dir[p];
            3'd1:    return m_pol[p];
            3'd4:    return exp_gpio(p);
            default: return m_lat[p];
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5eed_0042));
        for (int p = 0; p < 2; p++) begin
            m_dir[p] = 8'hFF; m_pol[p] = 8'h00; m_lat[p] = 8'h00;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 oe", gpio_oe, 16'h0000);
        chk("R1 out", gpio_out, 16'h0000);
        chk("R1 irq", irq, 1'b0);
        chk("R1 miso", miso, 1'b0);
        rd(8'h00, r); chk("R1 dirA", r, 8'hFF);
        rd(8'h01, r); chk("R1 dirB", r, 8'hFF);
        rd(8'h0A, r); chk("R1 latA", r, 8'h00);

        // R3 R4 R5 R6 random register traffic
        for (int it = 0; it < 48; it++) begin
            logic [2:0] s, s2;
            int p, p2;
            logic [7:0] dv;
            case ($urandom % 4) 0: s = 3'd0; 1: s = 3'd1; 2: s = 3'd4; default: s = 3'd5; endcase
            p  = int'($urandom % 2);
            dv = 8'($urandom);
            gpio_in = 16'($urandom);
            wr({4'h0, s, 1'(p)}, dv);
            case (s)
                3'd0:    m_dir[p] = dv;
                3'd1:    m_pol[p] = dv;
                default: m_lat[p] = dv;
            endcase
            chk("R4 oe", gpio_oe, {~m_dir[1], ~m_dir[0]});
            chk("R4 out", gpio_out, {~m_dir[1] & m_lat[1], ~m_dir[0] & m_lat[0]});
            case ($urandom % 4) 0: s2 = 3'd0; 1: s2 = 3'd1; 2: s2 = 3'd4; default: s2 = 3'd5; endcase
            p2 = int'($urandom % 2);
            rd({4'h0, s2, 1'(p2)}, r);
            chk(s2 == 3'd4 ? "R6 gpio read" : "R3 R5 readback", r, exp_reg(s2, p2));
        end

        // R2 wrong opcode writes nothing and reads zero
        wr(8'h0A, m_lat[0]);
        xfer(8'h44, 8'h0A, ~m_lat[0], 24, r);
        rd(8'h0A, r); chk("R2 bad write opcode", r, m_lat[0]);
        xfer(8'h43, 8'h0A, 8'h00, 24, r); chk("R2 bad read opcode", r, 8'h00);

        // R10 aborted frame, unmapped reads
        xfer(8'h40, 8'h0A, ~m_lat[0], 20, r);
        rd(8'h0A, r); chk("R10 abort", r, m_lat[0]);
        rd(8'h20, r); chk("R10 unmapped high", r, 8'h00);
        rd(8'h0C, r); chk("R10 unmapped sel", r, 8'h00);

        // R7 R8 R9 R11 interrupt on change
        wr(8'h00, 8'hFF); wr(8'h01, 8'hFF); wr(8'h02, 8'h00); wr(8'h03, 8'h00);
        gpio_in = 16'h0000;
        repeat (6) @(negedge clk);
        rd(8'h08, r); rd(8'h09, r);
        wr(8'h04, 8'h01); wr(8'h05, 8'h80);
        chk("R7 no change", irq, 1'b0);
        gpio_in = 16'h0002;
        repeat (6) @(negedge clk);
        chk("R7 disabled pin", irq, 1'b0);
        gpio_in = 16'h0003;
        repeat (6) @(negedge clk);
        chk("R7 enabled change", irq, 1'b1);
        gpio_in = 16'h0007;
        repeat (6) @(negedge clk);
        rd(8'h06, r); chk("R9 capture first", r, 8'h03);
        chk("R8 cleared by capture read", irq, 1'b0);
        wr(8'h06, 8'hAA);
        xfer(8'h40, 8'h1E, 8'h55, 24, r);
        rd(8'h06, r); chk("R11 capture write ignored", r, 8'h03);
        gpio_in = 16'h8007;
        repeat (6) @(negedge clk);
        chk("R7 port B change", irq, 1'b1);
        rd(8'h08, r); chk("R6 gpio A", r, 8'h07);
        chk("R8 other port kept", irq, 1'b1);
        rd(8'h09, r); chk("R6 gpio B", r, 8'h80);
        chk("R8 port B cleared", irq, 1'b0);
        gpio_in = 16'h8006;
        repeat (6) @(negedge clk);
        chk("R7 change after new reference", irq, 1'b1);
        rd(8'h08, r);
        chk("R8 final clear", irq, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule